// File: doc/BRIEF.md
# Command-Status Flash Bank Sequencer

This block erases or programs one bank of a byte-wide flash device. The device is driven through command-register writes and reports progress in a status register. A host asks for an operation by pulsing a start line with a bank number and an operation select. Erase clears every byte of the bank to 0xFF. Program copies the bank's contents from an image buffer, one byte at a time, through an asynchronous read port.

For every operation the sequencer does the following. It issues the device commands. It polls the status register until the ready bit rises or a bounded attempt count runs out. It clears status, returns the device to array-read mode and reads the whole bank back. It then pulses done with a two-bit result code. Each bus access is a write or read strobe held until the device side acknowledges it, so a slow device can stretch any access.

Top module: `flash_bank_seq`

## Requirements
- R1: Bank b occupies flash bytes b*BANK_BYTES to b*BANK_BYTES+BANK_BYTES-1. Every access of an operation stays inside the requested bank. Commands go to the bank's first byte, called the base.
- R2: Erase writes 0x20 and then 0xD0 to the base, then polls status.
- R3: A status poll writes 0x70 to the base and then reads the base. Bit 7 (0x80) set means ready. A strobe stays high, with stable address and data, until fl_ack_i. A write strobe and a read strobe are never high together.
- R4: Program treats bytes in ascending order. For byte i it writes 0x40 to base+i and then writes image byte i to base+i, with img_addr_o = i. It then polls status before moving to the next byte.
- R5: Between the acknowledge of the 0x40 write and the start of the data write there are at least CLK_MHZ clock cycles, which is 1 µs.
- R6: POLL_MAX consecutive not-ready status reads end polling with a timeout. A timeout during program stops the byte loop. Timeout gives result code 1, which takes priority over all other results.
- R7: After polling ends, whether ready or timed out, the block writes 0x50 and then 0xFF to the base before any read-back.
- R8: A ready status read that has any of bits 0x38 set marks a device error. It gives result code 2 unless a timeout occurred.
- R9: Read-back visits the bank's bytes in ascending order. After erase each byte must be 0xFF. After program each byte must equal the image. The first mismatch ends the read-back. A mismatch gives result code 3 when neither a timeout nor a device error occurred. Code 0 means success.
- R10: done_o is a one-cycle pulse carrying result_o. busy_o is high from the accepted start until done, and low in the cycle after done. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, accepted when idle |
| bank_i | input | BANK_W | Bank number |
| op_i | input | 1 | 0 erase, 1 program |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | 0 ok, 1 timeout, 2 device error, 3 verify mismatch |
| img_addr_o | output | IDX_W | Image buffer byte index |
| img_data_i | input | 8 | Image byte at img_addr_o, same cycle |
| fl_wr_o | output | 1 | Flash write strobe |
| fl_rd_o | output | 1 | Flash read strobe |
| fl_addr_o | output | FA_W | Flash byte address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_ack_i | input | 1 | Access acknowledge |
| fl_rdata_i | input | 8 | Read data, valid with fl_ack_i |

## Verification
Some properties are checked on every cycle. The strobes are exclusive and held steady until acknowledged. The bank and operation are frozen while busy. Done is followed by idle. The poll counter never counts past its limit. The pointer never steps past the last byte. Arming the gap timer always leaves it unexpired for at least a cycle.

The command order, the minimum microsecond gap as measured on the bus, and the exact poll count at timeout can only be shown by the bench's scenarios against a flash model. So can the halt of the program loop on timeout, the result priority, the early stop of read-back, and leaving the other bank untouched.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam logic [7:0] CMD_ERASE_ARM = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO  = 8'hD0;
  localparam logic [7:0] CMD_PROG_ARM  = 8'h40;
  localparam logic [7:0] CMD_STATUS    = 8'h70;
  localparam logic [7:0] CMD_CLEAR     = 8'h50;
  localparam logic [7:0] CMD_ARRAY     = 8'hFF;
  localparam logic [7:0] ST_ERR_MASK   = 8'h38;
  localparam int         ST_READY_BIT  = 7;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_TIMEOUT = 2'd1,
    RES_DEV_ERR = 2'd2,
    RES_VERIFY  = 2'd3
  } fbs_res_e;

  typedef enum logic [3:0] {
    S_IDLE, S_ER_ARM, S_ER_GO, S_PG_ARM, S_PG_GAP, S_PG_DATA,
    S_POLL_CMD, S_POLL_RD, S_CLR, S_RST, S_VFY, S_DONE
  } fbs_state_e;
endpackage

// File: rtl/fbs_gap_timer.sv
module fbs_gap_timer #(
  parameter int CYC = 125,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYC);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  a_r5_gap_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !expired_o);
endmodule

// File: rtl/fbs_try_cnt.sv
module fbs_try_cnt #(
  parameter int LIMIT = 1000000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == CW'(LIMIT - 1));

  a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/fbs_byte_ptr.sv
module fbs_byte_ptr #(
  parameter int N = 8192,
  localparam int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (inc_i)  idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == IW'(N - 1));

  a_r9_ptr_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> !last_o);
endmodule

// File: rtl/flash_bank_seq.sv
module flash_bank_seq
  import fbs_pkg::*;
#(
  parameter int BANK_BYTES = 8192,
  parameter int NUM_BANKS  = 2,
  parameter int CLK_MHZ    = 125,
  parameter int POLL_MAX   = 1000000,
  localparam int IDX_W  = $clog2(BANK_BYTES),
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int FA_W   = IDX_W + BANK_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              op_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [IDX_W-1:0]  img_addr_o,
  input  logic [7:0]        img_data_i,
  output logic              fl_wr_o,
  output logic              fl_rd_o,
  output logic [FA_W-1:0]   fl_addr_o,
  output logic [7:0]        fl_wdata_o,
  input  logic              fl_ack_i,
  input  logic [7:0]        fl_rdata_i
);
  fbs_state_e        state_q, state_d;
  logic [BANK_W-1:0] bank_q;
  logic              op_q;
  logic              to_q, err_q, vbad_q;
  logic              set_to, set_err, set_vbad;
  logic              ptr_clr, ptr_inc, ptr_last;
  logic              try_clr, try_inc, try_last;
  logic              gap_start, gap_done;
  logic [IDX_W-1:0]  idx;
  logic [7:0]        vfy_exp;
  logic              accept;

  fbs_byte_ptr #(.N(BANK_BYTES)) u_ptr (
    .clk_i, .rst_ni, .clr_i(ptr_clr), .inc_i(ptr_inc), .idx_o(idx), .last_o(ptr_last)
  );

  fbs_try_cnt #(.LIMIT(POLL_MAX)) u_tries (
    .clk_i, .rst_ni, .clr_i(try_clr), .inc_i(try_inc), .last_o(try_last)
  );

  fbs_gap_timer #(.CYC(CLK_MHZ)) u_gap (
    .clk_i, .rst_ni, .start_i(gap_start), .expired_o(gap_done)
  );

  assign accept  = (state_q == S_IDLE) && start_i;
  assign vfy_exp = op_q ? img_data_i : 8'hFF;

  always_comb begin
    state_d   = state_q;
    ptr_clr   = 1'b0;
    ptr_inc   = 1'b0;
    try_clr   = 1'b0;
    try_inc   = 1'b0;
    gap_start = 1'b0;
    set_to    = 1'b0;
    set_err   = 1'b0;
    set_vbad  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        ptr_clr = 1'b1;
        state_d = op_i ? S_PG_ARM : S_ER_ARM;
      end
      S_ER_ARM:  if (fl_ack_i) state_d = S_ER_GO;
      S_ER_GO:   if (fl_ack_i) begin try_clr = 1'b1; state_d = S_POLL_CMD; end
      S_PG_ARM:  if (fl_ack_i) begin gap_start = 1'b1; state_d = S_PG_GAP; end
      S_PG_GAP:  if (gap_done) state_d = S_PG_DATA;
      S_PG_DATA: if (fl_ack_i) begin try_clr = 1'b1; state_d = S_POLL_CMD; end
      S_POLL_CMD: if (fl_ack_i) state_d = S_POLL_RD;
      S_POLL_RD: if (fl_ack_i) begin
        if (fl_rdata_i[ST_READY_BIT]) begin
          set_err = |(fl_rdata_i & ST_ERR_MASK);
          if (op_q && !ptr_last) begin
            ptr_inc = 1'b1;
            state_d = S_PG_ARM;
          end else begin
            state_d = S_CLR;
          end
        end else if (try_last) begin
          set_to  = 1'b1;  // abandons remaining bytes
          state_d = S_CLR;
        end else begin
          try_inc = 1'b1;
          state_d = S_POLL_CMD;
        end
      end
      S_CLR: if (fl_ack_i) state_d = S_RST;
      S_RST: if (fl_ack_i) begin ptr_clr = 1'b1; state_d = S_VFY; end
      S_VFY: if (fl_ack_i) begin
        if (fl_rdata_i != vfy_exp) begin
          set_vbad = 1'b1;
          state_d  = S_DONE;
        end else if (ptr_last) begin
          state_d = S_DONE;
        end else begin
          ptr_inc = 1'b1;
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      bank_q  <= '0;
      op_q    <= 1'b0;
      to_q    <= 1'b0;
      err_q   <= 1'b0;
      vbad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        bank_q <= bank_i;
        op_q   <= op_i;
        to_q   <= 1'b0;
        err_q  <= 1'b0;
        vbad_q <= 1'b0;
      end else begin
        to_q   <= to_q   | set_to;
        err_q  <= err_q  | set_err;
        vbad_q <= vbad_q | set_vbad;
      end
    end
  end

  always_comb begin
    fl_wr_o    = 1'b0;
    fl_rd_o    = 1'b0;
    fl_wdata_o = 8'h00;
    fl_addr_o  = {bank_q, {IDX_W{1'b0}}};
    unique case (state_q)
      S_ER_ARM:   begin fl_wr_o = 1'b1; fl_wdata_o = CMD_ERASE_ARM; end
      S_ER_GO:    begin fl_wr_o = 1'b1; fl_wdata_o = CMD_ERASE_GO;  end
      S_PG_ARM:   begin fl_wr_o = 1'b1; fl_wdata_o = CMD_PROG_ARM; fl_addr_o = {bank_q, idx}; end
      S_PG_DATA:  begin fl_wr_o = 1'b1; fl_wdata_o = img_data_i;   fl_addr_o = {bank_q, idx}; end
      S_POLL_CMD: begin fl_wr_o = 1'b1; fl_wdata_o = CMD_STATUS; end
      S_POLL_RD:  fl_rd_o = 1'b1;
      S_CLR:      begin fl_wr_o = 1'b1; fl_wdata_o = CMD_CLEAR; end
      S_RST:      begin fl_wr_o = 1'b1; fl_wdata_o = CMD_ARRAY; end
      S_VFY:      begin fl_rd_o = 1'b1; fl_addr_o = {bank_q, idx}; end
      default: ;
    endcase
  end

  assign img_addr_o = idx;
  assign busy_o     = (state_q != S_IDLE);
  assign done_o     = (state_q == S_DONE);
  assign result_o   = to_q  ? RES_TIMEOUT :
                      err_q ? RES_DEV_ERR :
                      vbad_q ? RES_VERIFY : RES_OK;

  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_wr_o && fl_rd_o));
  a_r3_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_wr_o && !fl_ack_i) |=> fl_wr_o && $stable(fl_addr_o) && $stable(fl_wdata_o));
  a_r3_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_rd_o && !fl_ack_i) |=> fl_rd_o && $stable(fl_addr_o));
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o && !done_o);
  a_r10_req_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(bank_q) && $stable(op_q));
endmodule

// File: tb/flash_bank_seq_bench.sv
module flash_bank_seq_bench;
  localparam int B    = 16;
  localparam int NB   = 2;
  localparam int MHZ  = 6;
  localparam int PM   = 8;
  localparam int IW   = $clog2(B);
  localparam int FW   = IW + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          start = 1'b0;
  logic          bank = 1'b0;
  logic          op = 1'b0;
  logic          busy, done;
  logic [1:0]    result;
  logic [IW-1:0] img_addr;
  logic [7:0]    img_data;
  logic          fl_wr, fl_rd, fl_ack;
  logic [FW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata;

  logic [7:0] img [0:B-1];
  assign img_data = img[img_addr];

  flash_bank_seq #(.BANK_BYTES(B), .NUM_BANKS(NB), .CLK_MHZ(MHZ), .POLL_MAX(PM)) u_flash_bank_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bank_i(bank), .op_i(op),
    .busy_o(busy), .done_o(done), .result_o(result),
    .img_addr_o(img_addr), .img_data_i(img_data),
    .fl_wr_o(fl_wr), .fl_rd_o(fl_rd), .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata),
    .fl_ack_i(fl_ack), .fl_rdata_i(fl_rdata)
  );

  // flash device model
  logic [7:0] mem [0:B*NB-1];
  int cyc = 0, wcnt = 0, t_arm = 0, busy_left = 0;
  bit in_req = 0, er_arm = 0, prog_arm = 0, stat_mode = 0, last50 = 0;
  int busy_cfg = 0, bad_addr = -1, gap_min = 1000;
  logic [7:0] err_cfg = 8'h00;
  int polls = 0, prog_writes = 0, erase_cnt = 0, endseq = 0, arr_reads = 0;

  always @(posedge clk) begin
    cyc++;
    fl_ack <= 1'b0;
    if ((fl_wr || fl_rd) && !fl_ack) begin
      if (!in_req) begin
        in_req = 1;
        wcnt = cyc % 3;
        if (fl_wr && prog_arm && (cyc - t_arm) < gap_min) gap_min = cyc - t_arm;
      end else if (wcnt == 0) begin
        in_req = 0;
        fl_ack <= 1'b1;
        if (fl_wr) begin
          if (prog_arm) begin
            mem[fl_addr] = fl_wdata ^ ((int'(fl_addr) == bad_addr) ? 8'h01 : 8'h00);
            prog_arm = 0;
            busy_left = busy_cfg;
            prog_writes++;
          end else begin
            if (fl_wdata == 8'hD0 && er_arm) begin
              for (int i = 0; i < B; i++) mem[(int'(fl_addr) / B) * B + i] = 8'hFF;
              erase_cnt++;
              busy_left = busy_cfg;
            end
            if (fl_wdata == 8'h40) begin prog_arm = 1; t_arm = cyc; end
            if (fl_wdata == 8'h70) stat_mode = 1;
            if (fl_wdata == 8'hFF) begin stat_mode = 0; if (last50) endseq++; end
            er_arm = (fl_wdata == 8'h20);
            last50 = (fl_wdata == 8'h50);
          end
        end else if (stat_mode) begin
          polls++;
          if (busy_left > 0) begin busy_left--; fl_rdata <= 8'h00; end
          else fl_rdata <= 8'h80 | err_cfg;
        end else begin
          arr_reads++;
          fl_rdata <= mem[fl_addr];
        end
      end else begin
        wcnt--;
      end
    end
  end

  int n_chk = 0, n_fail = 0, n_done = 0;
  int exp_q [$];

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected done", int'(result), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(int'(result) == e, "R6/R8/R9 result code", int'(result), e);
      end
    end
  end

  task automatic clr_stats();
    polls = 0; prog_writes = 0; erase_cnt = 0; endseq = 0; arr_reads = 0; gap_min = 1000;
  endtask

  task automatic run_op(input bit b, input bit o, input int exp_res);
    int d0;
    d0 = n_done;
    exp_q.push_back(exp_res);
    @(negedge clk);
    bank = b; op = o; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (n_done == d0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", cyc, 0);
    finish_run();
  end

  initial begin
    int mism;
    for (int i = 0; i < B; i++) img[i] = 8'((i * 37 + 5) & 8'hFF);
    for (int i = 0; i < B * NB; i++) mem[i] = 8'h11;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fl_wr && !fl_rd, "R10 reset idle", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fl_wr && !fl_rd, "R3 no strobe idle", int'(fl_wr), 0);

    // erase bank 1, three busy polls
    clr_stats(); busy_cfg = 3; err_cfg = 8'h00;
    run_op(1'b1, 1'b0, 0);
    mism = 0;
    for (int i = 0; i < B; i++) if (mem[B + i] != 8'hFF) mism++;
    check(mism == 0, "R2 bank1 erased", mism, 0);
    check(erase_cnt == 1, "R2 erase command pair", erase_cnt, 1);
    mism = 0;
    for (int i = 0; i < B; i++) if (mem[i] != 8'h11) mism++;
    check(mism == 0, "R1 bank0 untouched", mism, 0);
    check(polls == 4, "R3 poll count", polls, 4);
    check(endseq == 1, "R7 clear then reset", endseq, 1);
    check(arr_reads == B, "R9 full readback", arr_reads, B);

    // program bank 1
    clr_stats(); busy_cfg = 1;
    run_op(1'b1, 1'b1, 0);
    mism = 0;
    for (int i = 0; i < B; i++) if (mem[B + i] != img[i]) mism++;
    check(mism == 0, "R4 bank1 programmed", mism, 0);
    check(prog_writes == B, "R4 byte writes", prog_writes, B);
    check(gap_min >= MHZ, "R5 setup-data gap", gap_min, MHZ);
    check(polls == 2 * B, "R4 poll per byte", polls, 2 * B);
    check(endseq == 1, "R7 end sequence program", endseq, 1);

    // erase timeout
    clr_stats(); busy_cfg = 100;
    run_op(1'b0, 1'b0, 1);
    check(polls == PM, "R6 erase poll limit", polls, PM);
    check(endseq == 1, "R7 end sequence after timeout", endseq, 1);

    // program timeout halts loop
    clr_stats(); busy_cfg = 100;
    run_op(1'b0, 1'b1, 1);
    check(prog_writes == 1, "R6 program loop stops", prog_writes, 1);
    check(polls == PM, "R6 program poll limit", polls, PM);

    // device error on completion
    clr_stats(); busy_cfg = 0; err_cfg = 8'h10;
    run_op(1'b1, 1'b0, 2);
    check(erase_cnt == 1, "R8 erase still done", erase_cnt, 1);
    err_cfg = 8'h00;

    // verify mismatch at byte 5
    clr_stats(); bad_addr = B + 5;
    run_op(1'b1, 1'b1, 3);
    check(arr_reads == 6, "R9 stop at first mismatch", arr_reads, 6);
    bad_addr = -1;

    // start ignored while busy
    clr_stats(); busy_cfg = 2;
    begin
      int d0;
      d0 = n_done;
      exp_q.push_back(0);
      @(negedge clk); bank = 1'b0; op = 1'b1; start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (10) @(negedge clk);
      bank = 1'b1; op = 1'b0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (n_done == d0) @(negedge clk);
      repeat (60) @(negedge clk);
      check(n_done == d0 + 1, "R10 extra start ignored", n_done - d0, 1);
      check(mem[B] == img[0], "R10 bank1 not erased", int'(mem[B]), int'(img[0]));
      check(erase_cnt == 0, "R10 no erase issued", erase_cnt, 0);
      mism = 0;
      for (int i = 0; i < B; i++) if (mem[i] != img[i]) mism++;
      check(mism == 0, "R4 bank0 programmed", mism, 0);
    end
    check(exp_q.size() == 0, "R10 all results seen", exp_q.size(), 0);
    finish_run();
  end
endmodule